// File: doc/BRIEF.md
# Scoped L1 Bulk Coherence Controller

This block is the controller of one core's private, write-back L1 data cache. Cores on a shared chip stay coherent without per-store invalidation traffic. Ordinary loads and stores stay in the L1. Coherence is enforced only at synchronization points, and each synchronization operation carries a scope. Work-group scope covers threads on the same core. That traffic is served entirely by the L1. Agent scope covers threads on other cores. It is served at the shared next-level cache, and the controller wraps it in coarse bulk actions: a full-cache flush before a release, and a full-cache invalidate after an acquire.

The core side is a valid/ready request port with a one-cycle response pulse. The memory side has a valid/ready request channel to the next level. Each accepted request gets exactly one response. The line store is direct mapped and holds one word per line. Requests are handled one at a time. While a request is in progress, including any flush walk or invalidate, the core port is held not ready.

Top module: `scoped_l1_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, nl_req_valid_o is 0, and every L1 line is invalid, so the first access to any address reaches the next level.
- R2: Plain loads (op 0) and stores (op 1) use write-back, write-allocate. A store allocates its line without a fetch and marks it dirty, with no next-level write. A later load of the same word returns the stored value.
- R3: A load or read-modify-write that misses first writes back a dirty victim with a write (cmd 1), then fetches the word with a read (cmd 0). The value returned is the one held at the next level.
- R4: The scope input (0 = work-group, 1 = agent) is ignored for plain loads and stores. An agent-scope plain store stays in the L1.
- R5: Work-group-scope acquire-load (op 2), release-store (op 3) and atomic add (op 4) run in the L1 like plain accesses, with no flush and no invalidate. The atomic add returns the old value and stores old+operand. On hits they cause no next-level traffic.
- R6: An agent-scope release-store first writes back every dirty line and waits for each acknowledge. Only then does it issue its own write to the next level. Every line is clean afterwards.
- R7: An agent-scope acquire-load reads the word at the next level, then clears the valid and dirty state of every line in one cycle, without any writeback. Only after that does it respond with the value read.
- R8: An agent-scope atomic add flushes like R6, sends an add (cmd 2) to the next level, invalidates like R7, and returns the old value.
- R9: req_ready_o is 0 from the cycle after a request is accepted until its response. rsp_valid_o is a single-cycle pulse. Stores and releases respond with data 0.
- R10: A next-level request is held with unchanged command, address and data until nl_req_ready_i accepts it. Only one request is outstanding at a time.
- R11: A value stored plainly on one core and published by that core's agent-scope release becomes visible to a later agent-scope acquire followed by a load on another core. Before that release, it is not visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_op_i | input | 3 | 0 load, 1 store, 2 acquire-load, 3 release-store, 4 atomic add |
| req_scope_i | input | 1 | 0 work-group, 1 agent |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Store data or add operand |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_data_o | output | DW | Load data or old value; 0 for stores |
| nl_req_valid_o | output | 1 | Next-level request valid |
| nl_req_ready_i | input | 1 | Next level accepts the request |
| nl_req_cmd_o | output | 2 | 0 read, 1 write, 2 atomic add |
| nl_req_addr_o | output | AW | Next-level word address |
| nl_req_wdata_o | output | DW | Write data or add operand |
| nl_rsp_valid_i | input | 1 | Next-level response or write acknowledge |
| nl_rsp_data_i | input | DW | Read data or old value |

## Verification
The assertions assume that the next level answers each accepted request exactly once and never sends a response that was not asked for. They also assume that the core holds its request fields steady while valid is high and ready is low. The bench's shared-level model raises ready only when it has nothing outstanding, and it returns one response after a random latency. The core-side tasks drive every field on the falling edge and release valid right after acceptance. Stimulus mixes directed scope scenarios across two controller instances with random plain traffic that forces evictions. A final agent-scope release lets the next-level contents be compared with a reference.

// File: rtl/scl1_pkg.sv
package scl1_pkg;
  typedef enum logic [2:0] {
    OP_LD      = 3'd0,
    OP_ST      = 3'd1,
    OP_LD_ACQ  = 3'd2,
    OP_ST_REL  = 3'd3,
    OP_RMW_ADD = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    NL_RD  = 2'd0,
    NL_WR  = 2'd1,
    NL_ADD = 2'd2
  } nl_cmd_e;
endpackage

// File: rtl/scl1_line_store.sv
module scl1_line_store #(
  parameter int unsigned SETS = 8,
  parameter int unsigned IW   = 3,
  parameter int unsigned TW   = 5,
  parameter int unsigned DW   = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output logic          rd_valid_o,
  output logic          rd_dirty_o,
  output logic [TW-1:0] rd_tag_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_dirty_i,
  input  logic          clean_en_i,
  input  logic [IW-1:0] clean_idx_i,
  input  logic          inv_all_i,
  output logic          any_valid_o,
  output logic          any_dirty_o
);
  logic          valid_q [SETS];
  logic          dirty_q [SETS];
  logic [TW-1:0] tag_q   [SETS];
  logic [DW-1:0] data_q  [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (inv_all_i) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IW'(g)) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= wr_dirty_i;
        tag_q[g]   <= wr_tag_i;
        data_q[g]  <= wr_data_i;
      end else if (clean_en_i && clean_idx_i == IW'(g)) begin
        dirty_q[g] <= 1'b0;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];

  always_comb begin
    any_valid_o = 1'b0;
    any_dirty_o = 1'b0;
    for (int i = 0; i < SETS; i++) begin
      any_valid_o = any_valid_o | valid_q[i];
      any_dirty_o = any_dirty_o | (valid_q[i] & dirty_q[i]);
    end
  end

  // R1: nothing valid right after reset
  a_r1_empty_after_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !any_valid_o);
endmodule

// File: rtl/scl1_flush_walker.sv
module scl1_flush_walker #(
  parameter int unsigned SETS = 8,
  parameter int unsigned IW   = 3,
  parameter int unsigned TW   = 5,
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [IW-1:0] idx_o,
  input  logic          line_valid_i,
  input  logic          line_dirty_i,
  input  logic [TW-1:0] line_tag_i,
  input  logic [DW-1:0] line_data_i,
  output logic          wb_valid_o,
  input  logic          wb_ready_i,
  output logic [AW-1:0] wb_addr_o,
  output logic [DW-1:0] wb_data_o,
  input  logic          wb_ack_i,
  output logic          clean_o
);
  typedef enum logic [1:0] {W_IDLE, W_SCAN, W_REQ, W_WAIT} wstate_e;
  localparam logic [IW-1:0] LAST = IW'(SETS - 1);

  wstate_e       st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          is_last;

  assign is_last = (idx_q == LAST);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    done_o  = 1'b0;
    clean_o = 1'b0;
    unique case (st_q)
      W_IDLE: if (start_i) begin
        st_d  = W_SCAN;
        idx_d = '0;
      end
      W_SCAN: begin
        if (line_valid_i && line_dirty_i) st_d = W_REQ;
        else if (is_last) begin
          done_o = 1'b1;
          st_d   = W_IDLE;
        end else idx_d = idx_q + 1'b1;
      end
      W_REQ: if (wb_ready_i) st_d = W_WAIT;
      W_WAIT: if (wb_ack_i) begin
        clean_o = 1'b1;
        if (is_last) begin
          done_o = 1'b1;
          st_d   = W_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = W_SCAN;
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= W_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign busy_o     = (st_q != W_IDLE);
  assign idx_o      = idx_q;
  assign wb_valid_o = (st_q == W_REQ);
  assign wb_addr_o  = {line_tag_i, idx_q};
  assign wb_data_o  = line_data_i;

  // R10: writeback request held until taken
  a_r10_wb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_ready_i |=> wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o));
  // R6: a walk never restarts while running
  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/scoped_l1_ctrl.sv
module scoped_l1_ctrl #(
  parameter int unsigned SETS = 8,
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [2:0]    req_op_i,
  input  logic          req_scope_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          nl_req_valid_o,
  input  logic          nl_req_ready_i,
  output logic [1:0]    nl_req_cmd_o,
  output logic [AW-1:0] nl_req_addr_o,
  output logic [DW-1:0] nl_req_wdata_o,
  input  logic          nl_rsp_valid_i,
  input  logic [DW-1:0] nl_rsp_data_i
);
  import scl1_pkg::*;

  localparam int unsigned IW = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int unsigned TW = AW - IW;

  typedef enum logic [3:0] {
    S_IDLE, S_LOCAL, S_WB_REQ, S_WB_WAIT, S_FILL_REQ, S_FILL_WAIT,
    S_FLUSH, S_NL_REQ, S_NL_WAIT, S_INV, S_RESP
  } state_e;

  state_e        st_q, st_d;
  op_e           op_q, req_op;
  logic          agent_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, rdata_d;
  logic [IW-1:0] idx_q;
  logic [TW-1:0] tag_q;

  logic          rd_valid, rd_dirty, any_valid, any_dirty;
  logic [TW-1:0] rd_tag;
  logic [DW-1:0] rd_data;
  logic [IW-1:0] rd_idx;
  logic          wr_en, wr_dirty, clean_top, inv_all;
  logic [TW-1:0] wr_tag;
  logic [DW-1:0] wr_data;

  logic          walk_start, walk_busy, walk_done, walk_clean;
  logic [IW-1:0] walk_idx;
  logic          wb_valid;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  logic          accept, sync_op, hit, is_write;
  nl_cmd_e       cmd;

  assign req_op  = op_e'(req_op_i);
  assign accept  = req_valid_i && req_ready_o;
  assign sync_op = (req_op == OP_LD_ACQ) || (req_op == OP_ST_REL) || (req_op == OP_RMW_ADD);
  assign idx_q   = addr_q[IW-1:0];
  assign tag_q   = addr_q[AW-1:IW];
  assign hit     = rd_valid && (rd_tag == tag_q);
  assign is_write = (op_q == OP_ST) || (op_q == OP_ST_REL);
  assign rd_idx  = walk_busy ? walk_idx : idx_q;
  assign walk_start = accept && req_scope_i && sync_op && (req_op != OP_LD_ACQ);

  scl1_line_store #(.SETS(SETS), .IW(IW), .TW(TW), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_dirty_o(rd_dirty),
    .rd_tag_o(rd_tag), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_idx_i(idx_q), .wr_tag_i(wr_tag), .wr_data_i(wr_data),
    .wr_dirty_i(wr_dirty),
    .clean_en_i(walk_clean | clean_top), .clean_idx_i(rd_idx),
    .inv_all_i(inv_all), .any_valid_o(any_valid), .any_dirty_o(any_dirty)
  );

  scl1_flush_walker #(.SETS(SETS), .IW(IW), .TW(TW), .AW(AW), .DW(DW)) u_walk (
    .clk_i, .rst_ni,
    .start_i(walk_start), .busy_o(walk_busy), .done_o(walk_done), .idx_o(walk_idx),
    .line_valid_i(rd_valid), .line_dirty_i(rd_dirty), .line_tag_i(rd_tag),
    .line_data_i(rd_data),
    .wb_valid_o(wb_valid), .wb_ready_i(nl_req_ready_i), .wb_addr_o(wb_addr),
    .wb_data_o(wb_data), .wb_ack_i(nl_rsp_valid_i), .clean_o(walk_clean)
  );

  // main sequencer
  always_comb begin
    st_d      = st_q;
    rdata_d   = rdata_q;
    wr_en     = 1'b0;
    wr_dirty  = 1'b0;
    wr_tag    = tag_q;
    wr_data   = wdata_q;
    clean_top = 1'b0;
    inv_all   = 1'b0;
    unique case (st_q)
      S_IDLE: if (accept) begin
        if (req_scope_i && sync_op)
          st_d = (req_op == OP_LD_ACQ) ? S_NL_REQ : S_FLUSH;
        else
          st_d = S_LOCAL;
      end
      S_LOCAL: begin
        if (hit || (is_write && !(rd_valid && rd_dirty))) begin
          st_d = S_RESP;
          if (is_write) begin
            wr_en    = 1'b1;
            wr_dirty = 1'b1;
            rdata_d  = '0;
          end else if (op_q == OP_RMW_ADD) begin
            wr_en    = 1'b1;
            wr_dirty = 1'b1;
            wr_data  = rd_data + wdata_q;
            rdata_d  = rd_data;
          end else begin
            rdata_d = rd_data;
          end
        end else if (rd_valid && rd_dirty) st_d = S_WB_REQ;
        else st_d = S_FILL_REQ;
      end
      S_WB_REQ:  if (nl_req_ready_i) st_d = S_WB_WAIT;
      S_WB_WAIT: if (nl_rsp_valid_i) begin
        clean_top = 1'b1;
        st_d      = S_LOCAL;
      end
      S_FILL_REQ:  if (nl_req_ready_i) st_d = S_FILL_WAIT;
      S_FILL_WAIT: if (nl_rsp_valid_i) begin
        wr_en   = 1'b1;
        wr_data = nl_rsp_data_i;
        st_d    = S_LOCAL;
      end
      S_FLUSH:  if (walk_done) st_d = S_NL_REQ;
      S_NL_REQ: if (nl_req_ready_i) st_d = S_NL_WAIT;
      S_NL_WAIT: if (nl_rsp_valid_i) begin
        if (op_q == OP_ST_REL) begin
          rdata_d = '0;
          wr_en   = hit;  // keep a clean copy coherent with the shared level
          st_d    = S_RESP;
        end else begin
          rdata_d = nl_rsp_data_i;
          st_d    = S_INV;
        end
      end
      S_INV: begin
        inv_all = 1'b1;
        st_d    = S_RESP;
      end
      S_RESP:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= OP_LD;
      agent_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      rdata_q <= rdata_d;
      if (accept) begin
        op_q    <= req_op;
        agent_q <= req_scope_i && sync_op;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  // next-level port mux
  always_comb begin
    nl_req_valid_o = 1'b0;
    cmd            = NL_RD;
    nl_req_addr_o  = addr_q;
    nl_req_wdata_o = wdata_q;
    if (wb_valid) begin
      nl_req_valid_o = 1'b1;
      cmd            = NL_WR;
      nl_req_addr_o  = wb_addr;
      nl_req_wdata_o = wb_data;
    end else begin
      unique case (st_q)
        S_WB_REQ: begin
          nl_req_valid_o = 1'b1;
          cmd            = NL_WR;
          nl_req_addr_o  = {rd_tag, idx_q};
          nl_req_wdata_o = rd_data;
        end
        S_FILL_REQ: nl_req_valid_o = 1'b1;
        S_NL_REQ: begin
          nl_req_valid_o = 1'b1;
          unique case (op_q)
            OP_ST_REL:  cmd = NL_WR;
            OP_RMW_ADD: cmd = NL_ADD;
            default:    cmd = NL_RD;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign nl_req_cmd_o = cmd;
  assign req_ready_o  = (st_q == S_IDLE);
  assign rsp_valid_o  = (st_q == S_RESP);
  assign rsp_data_o   = rdata_q;

  // R9: core stalled during a bulk walk
  a_r9_stall_on_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_busy |-> !req_ready_o);
  // R9: single-cycle response
  a_r9_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R10: next-level request stable until accepted
  a_r10_nl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nl_req_valid_o && !nl_req_ready_i |=> nl_req_valid_o && $stable(nl_req_cmd_o)
      && $stable(nl_req_addr_o) && $stable(nl_req_wdata_o));
  // R6: release store leaves only after every dirty line is written back
  a_r6_clean_before_rel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_NL_REQ) && agent_q && (op_q == OP_ST_REL) |-> !any_dirty);
  // R7: bulk invalidate empties the cache in one cycle
  a_r7_inv_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_INV) |=> !any_valid);
  // R5: work-group ops never trigger a walk or invalidate
  a_r5_wg_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LOCAL) |-> !walk_busy && !inv_all);
endmodule

// File: tb/scoped_l1_ctrl_test.sv
module scoped_l1_ctrl_test;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_v [2];
  logic          req_rdy [2];
  logic [2:0]    req_op [2];
  logic          req_sc [2];
  logic [AW-1:0] req_a [2];
  logic [DW-1:0] req_d [2];
  logic          rsp_v [2];
  logic [DW-1:0] rsp_d [2];
  logic          nl_v [2];
  logic          nl_rdy [2];
  logic [1:0]    nl_cmd [2];
  logic [AW-1:0] nl_a [2];
  logic [DW-1:0] nl_wd [2];
  logic          nl_rv [2];
  logic [DW-1:0] nl_rd [2];

  scoped_l1_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_v[0]), .req_ready_o(req_rdy[0]), .req_op_i(req_op[0]),
    .req_scope_i(req_sc[0]), .req_addr_i(req_a[0]), .req_wdata_i(req_d[0]),
    .rsp_valid_o(rsp_v[0]), .rsp_data_o(rsp_d[0]),
    .nl_req_valid_o(nl_v[0]), .nl_req_ready_i(nl_rdy[0]), .nl_req_cmd_o(nl_cmd[0]),
    .nl_req_addr_o(nl_a[0]), .nl_req_wdata_o(nl_wd[0]),
    .nl_rsp_valid_i(nl_rv[0]), .nl_rsp_data_i(nl_rd[0]));

  scoped_l1_ctrl peer (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_v[1]), .req_ready_o(req_rdy[1]), .req_op_i(req_op[1]),
    .req_scope_i(req_sc[1]), .req_addr_i(req_a[1]), .req_wdata_i(req_d[1]),
    .rsp_valid_o(rsp_v[1]), .rsp_data_o(rsp_d[1]),
    .nl_req_valid_o(nl_v[1]), .nl_req_ready_i(nl_rdy[1]), .nl_req_cmd_o(nl_cmd[1]),
    .nl_req_addr_o(nl_a[1]), .nl_req_wdata_o(nl_wd[1]),
    .nl_rsp_valid_i(nl_rv[1]), .nl_rsp_data_i(nl_rd[1]));

  // shared next-level model
  logic [DW-1:0] mem [256];
  logic          m_busy [2];
  int            m_lat [2];
  logic [DW-1:0] m_data [2];
  int            nl_cnt [2];
  int            wr_cnt [2];
  logic [AW-1:0] last_wr [2];

  function automatic logic [DW-1:0] init_val(input int a);
    return 32'h1000 + 32'(a) * 7;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    for (int p = 0; p < 2; p++) begin
      m_busy[p] = 1'b0; m_lat[p] = 0; m_data[p] = '0;
      nl_cnt[p] = 0; wr_cnt[p] = 0; last_wr[p] = '0;
      nl_rdy[p] = 1'b0; nl_rv[p] = 1'b0; nl_rd[p] = '0;
      req_v[p] = 1'b0; req_op[p] = '0; req_sc[p] = 1'b0; req_a[p] = '0; req_d[p] = '0;
    end
  end

  always @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      nl_rv[p] <= 1'b0;
      if (rst_n) begin
        if (!m_busy[p] && nl_v[p] && nl_rdy[p]) begin
          nl_cnt[p]++;
          case (nl_cmd[p])
            2'd0: m_data[p] = mem[nl_a[p]];
            2'd1: begin
              mem[nl_a[p]] = nl_wd[p];
              wr_cnt[p]++;
              last_wr[p] = nl_a[p];
              m_data[p] = '0;
            end
            default: begin
              m_data[p] = mem[nl_a[p]];
              mem[nl_a[p]] = mem[nl_a[p]] + nl_wd[p];
            end
          endcase
          m_busy[p] = 1'b1;
          m_lat[p]  = int'($urandom % 4);
        end else if (m_busy[p]) begin
          if (m_lat[p] == 0) begin
            nl_rv[p] <= 1'b1;
            nl_rd[p] <= m_data[p];
            m_busy[p] = 1'b0;
          end else m_lat[p]--;
        end
        nl_rdy[p] <= !m_busy[p] && ($urandom % 3 != 0);
      end
    end
  end

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit in_txn [2];
  int ready_viol = 0;
  int pulse_viol = 0;
  logic prev_rsp [2];

  initial begin
    in_txn[0] = 0; in_txn[1] = 0; prev_rsp[0] = 0; prev_rsp[1] = 0;
  end

  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (in_txn[p] && req_rdy[p]) ready_viol++;
      if (rsp_v[p] && prev_rsp[p]) pulse_viol++;
      prev_rsp[p] = rsp_v[p];
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input int p, input logic [2:0] op, input logic sc,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] r);
    @(negedge clk);
    req_v[p] = 1'b1; req_op[p] = op; req_sc[p] = sc; req_a[p] = a; req_d[p] = d;
    while (!req_rdy[p]) @(negedge clk);
    @(posedge clk);
    in_txn[p] = 1'b1;
    @(negedge clk);
    req_v[p] = 1'b0;
    while (!rsp_v[p]) @(negedge clk);
    r = rsp_d[p];
    in_txn[p] = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] r;
    logic [DW-1:0] ref_m [32];
    int c0, c1;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ready", 32'(req_rdy[0]), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_v[0]), 32'd0);
    chk("R1 nl_valid", 32'(nl_v[0]), 32'd0);
    c0 = nl_cnt[0];
    xfer(0, 3'd0, 1'b0, 8'h05, 0, r);
    chk("R3 load miss data", r, init_val(5));
    chk("R1 first access reaches next level", 32'(nl_cnt[0] - c0), 32'd1);
    // R2
    c0 = nl_cnt[0];
    xfer(0, 3'd1, 1'b0, 8'h05, 32'hAAAA, r);
    chk("R9 store rsp data", r, 32'd0);
    xfer(0, 3'd0, 1'b0, 8'h05, 0, r);
    chk("R2 load after store", r, 32'hAAAA);
    chk("R2 no next-level traffic", 32'(nl_cnt[0] - c0), 32'd0);
    chk("R2 write-back keeps memory old", mem[5], init_val(5));
    // R4
    c0 = nl_cnt[0];
    xfer(0, 3'd1, 1'b1, 8'h06, 32'h1234, r);
    xfer(0, 3'd0, 1'b1, 8'h06, 0, r);
    chk("R4 agent plain load", r, 32'h1234);
    chk("R4 agent plain no traffic", 32'(nl_cnt[0] - c0), 32'd0);
    chk("R4 memory untouched", mem[6], init_val(6));
    // R3 eviction
    xfer(0, 3'd1, 1'b0, 8'h0D, 32'hBBBB, r);
    chk("R3 dirty victim written", mem[5], 32'hAAAA);
    xfer(0, 3'd0, 1'b0, 8'h05, 0, r);
    chk("R3 refill after evict", r, 32'hAAAA);
    chk("R3 second victim written", mem[8'h0D], 32'hBBBB);
    // R5
    c0 = nl_cnt[0];
    xfer(0, 3'd3, 1'b0, 8'h07, 32'd77, r);
    xfer(0, 3'd2, 1'b0, 8'h07, 0, r);
    chk("R5 wg acquire", r, 32'd77);
    xfer(0, 3'd4, 1'b0, 8'h07, 32'd3, r);
    chk("R5 wg rmw old", r, 32'd77);
    xfer(0, 3'd0, 1'b0, 8'h07, 0, r);
    chk("R5 wg rmw new", r, 32'd80);
    chk("R5 wg no traffic", 32'(nl_cnt[0] - c0), 32'd0);
    // R6
    xfer(0, 3'd1, 1'b0, 8'h01, 32'd11, r);
    xfer(0, 3'd1, 1'b0, 8'h02, 32'd22, r);
    c0 = wr_cnt[0];
    xfer(0, 3'd3, 1'b1, 8'h20, 32'd1, r);
    chk("R6 write count", 32'(wr_cnt[0] - c0), 32'd5);
    chk("R6 release store last", 32'(last_wr[0]), 32'h20);
    chk("R6 line 1", mem[1], 32'd11);
    chk("R6 line 2", mem[2], 32'd22);
    chk("R6 line 6", mem[6], 32'h1234);
    chk("R6 line 7", mem[7], 32'd80);
    chk("R6 flag", mem[8'h20], 32'd1);
    c0 = wr_cnt[0];
    xfer(0, 3'd3, 1'b1, 8'h20, 32'd2, r);
    chk("R6 lines clean after flush", 32'(wr_cnt[0] - c0), 32'd1);
    // R11
    xfer(1, 3'd0, 1'b0, 8'h30, 0, r);
    chk("R11 peer initial", r, init_val(8'h30));
    xfer(0, 3'd1, 1'b0, 8'h30, 32'h5555, r);
    xfer(1, 3'd2, 1'b1, 8'h28, 0, r);
    chk("R7 acquire reads next level", r, init_val(8'h28));
    xfer(1, 3'd0, 1'b0, 8'h30, 0, r);
    chk("R11 not visible before release", r, init_val(8'h30));
    xfer(0, 3'd3, 1'b1, 8'h28, 32'd1, r);
    xfer(1, 3'd2, 1'b1, 8'h28, 0, r);
    chk("R11 flag seen", r, 32'd1);
    xfer(1, 3'd0, 1'b0, 8'h30, 0, r);
    chk("R11 data visible after release", r, 32'h5555);
    // R7 dirty dropped
    xfer(1, 3'd1, 1'b0, 8'h3A, 32'h9999, r);
    c1 = wr_cnt[1];
    xfer(1, 3'd2, 1'b1, 8'h28, 0, r);
    chk("R7 no writeback on invalidate", 32'(wr_cnt[1] - c1), 32'd0);
    xfer(1, 3'd0, 1'b0, 8'h3A, 0, r);
    chk("R7 dirty data dropped", r, init_val(8'h3A));
    // R8
    xfer(0, 3'd1, 1'b0, 8'h03, 32'd33, r);
    xfer(0, 3'd4, 1'b1, 8'h40, 32'd10, r);
    chk("R8 rmw old value", r, init_val(8'h40));
    chk("R8 rmw memory", mem[8'h40], init_val(8'h40) + 32'd10);
    chk("R8 flushed first", mem[3], 32'd33);
    c0 = nl_cnt[0];
    xfer(0, 3'd0, 1'b0, 8'h03, 0, r);
    chk("R8 invalidated after", r, 32'd33);
    chk("R8 refill traffic", 32'(nl_cnt[0] - c0), 32'd1);
    // random plain traffic, R2 and R3
    for (int i = 0; i < 32; i++) ref_m[i] = init_val(8'h80 + i);
    for (int i = 0; i < 300; i++) begin
      int k;
      logic [DW-1:0] d;
      k = int'($urandom % 32);
      d = $urandom;
      if ($urandom % 2 == 0) begin
        xfer(0, 3'd1, 1'($urandom % 2), 8'(8'h80 + k), d, r);
        ref_m[k] = d;
      end else begin
        xfer(0, 3'd0, 1'($urandom % 2), 8'(8'h80 + k), 0, r);
        chk("R3 random load", r, ref_m[k]);
      end
    end
    xfer(0, 3'd3, 1'b1, 8'hA0, 32'd7, r);
    for (int i = 0; i < 32; i++) chk("R6 random flush image", mem[8'h80 + i], ref_m[i]);
    chk("R9 ready low while busy", 32'(ready_viol), 32'd0);
    chk("R9 response single pulse", 32'(pulse_viol), 32'd0);
    summary();
  end
endmodule